// File: doc/BRIEF.md
# CAN Fault Confinement and Error Capture Unit

This unit keeps the transmit and receive error counters of a CAN node and derives the node's confinement state from them: error-active, error-passive or bus-off, plus a warning indication whose threshold software can program. The protocol engine drives single-cycle pulses that raise or lower the counters. It also reports each detected bus error with its type, its direction and the frame segment where it occurred, and each arbitration loss with the bit position where it happened.

The unit holds the most recent error detail and arbitration position. It presents a counter word, a warning-limit value and a status word, and it raises one-cycle event pulses for the interrupt unit. Software clears the counters and the captured detail by writing zero to the counter word. The protocol engine signals the end of bus-off recovery with a recovery pulse. Frame parsing and the interrupt masking logic sit in other blocks.

Top module: `can_fault_conf`

## Requirements
- R1: `cnt_word` carries the transmit error count in bits 7:0 and the receive error count in bits 23:16. All other bits read zero.
- R2: A `tx_fail` pulse adds 8 to the transmit count. A `tx_ok` pulse subtracts 1, and the count never goes below 0. A `rx_fail` pulse adds 1 and a `rx_fail_big` pulse adds 8, and both saturate the receive count at 255. A `rx_ok` pulse subtracts 1 with a floor of 0, except that a receive count above 127 is set to 119. Every change shows in the cycle after the pulse.
- R3: A `tx_fail` that would take the transmit count past 255 puts the node in bus-off. The transmit count then holds at 255 and status bit 7 reads 1. While the node is bus-off, all counter pulses are ignored.
- R4: A `recover` pulse while bus-off clears both counters and returns the node to error-active. A `recover` pulse outside bus-off has no effect.
- R5: A write of zero to the counter word (`wr_sel`=0) clears both counters, the bus-off condition, the captured error detail and the arbitration position. A nonzero write to the counter word has no effect.
- R6: The warning limit (`wr_sel`=1, data bits 7:0) resets to 96 and reads back on `limit_word`. Status bit 6 reads 1 whenever either counter is greater than or equal to the limit.
- R7: `node_state` reads 2 when the node is bus-off. Otherwise it reads 1 when either counter is above 127, and 0 in all other cases.
- R8: An `err_evt` pulse stores the error detail in the status word, where it appears one cycle later: the type in bits 23:22 (0 bit, 1 form, 2 stuff, 3 other), the direction in bit 21 (0 transmitting, 1 receiving), and the segment code in bits 20:16 (for example 0x03 start of frame, 0x0A data field, 0x1A end of frame). `ev_bus_err` pulses in that same cycle.
- R9: An `arb_lost` pulse stores `arb_pos` in status bits 12:8, one cycle later. `ev_arb_lost` pulses in that same cycle.
- R10: `ev_passive` pulses for exactly one cycle whenever the passive condition (either counter above 127) changes, on entry and on exit alike. The pulse comes in the first cycle in which the new counters are visible.
- R11: `ev_warn` pulses for exactly one cycle whenever status bit 6 or status bit 7 changes, in the first cycle in which the new value is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_fail | input | 1 | Transmit error: add 8 |
| tx_ok | input | 1 | Successful transmit: subtract 1 |
| rx_fail | input | 1 | Receive error: add 1 |
| rx_fail_big | input | 1 | Severe receive error: add 8 |
| rx_ok | input | 1 | Successful receive |
| recover | input | 1 | Bus-off recovery complete |
| err_evt | input | 1 | Bus error detected |
| err_type | input | 2 | Error type code |
| err_dir | input | 1 | 0 transmitting, 1 receiving |
| err_seg | input | 5 | Frame segment code |
| arb_lost | input | 1 | Arbitration lost |
| arb_pos | input | 5 | Bit position of the loss |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 counter word, 1 warning limit |
| wr_data | input | 32 | Write data |
| cnt_word | output | 32 | Counter word |
| limit_word | output | 8 | Warning limit |
| status_word | output | 32 | Status and capture fields |
| node_state | output | 2 | 0 active, 1 passive, 2 bus-off |
| ev_warn | output | 1 | Warning or bus-off status changed |
| ev_passive | output | 1 | Passive condition changed |
| ev_bus_err | output | 1 | Bus error captured |
| ev_arb_lost | output | 1 | Arbitration loss captured |

## Verification
Each input pulse is registered exactly once. The counters, the captured fields, the limit and the status bits therefore all change on the first rising edge after the pulse. The four event pulses are high during the cycle that immediately follows that edge. The bench drives one operation at a falling edge and lets one rising edge pass. At the next falling edge it compares every output with its model, and only then drives the next operation, so any event that lingers for a second cycle is caught at the following sample.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  localparam int CNT_W  = 8;
  localparam int SEG_W  = 5;
  localparam int TYPE_W = 2;
  localparam int POS_W  = 5;

  typedef enum logic [1:0] {
    ND_ACTIVE  = 2'd0,
    ND_PASSIVE = 2'd1,
    ND_BUSOFF  = 2'd2
  } node_st_e;

  typedef struct packed {
    logic [TYPE_W-1:0] etype;
    logic              dir;
    logic [SEG_W-1:0]  seg;
  } err_cap_t;

  // sum with carry out; the carry marks a pass beyond the counter range
  function automatic logic [CNT_W:0] fc_wide_add(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] s);
    return {1'b0, c} + {1'b0, s};
  endfunction

  function automatic logic [CNT_W-1:0] fc_sat_add(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] s);
    logic [CNT_W:0] w;
    w = fc_wide_add(c, s);
    return w[CNT_W] ? '1 : w[CNT_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] fc_dec(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] fc_rx_success(input logic [CNT_W-1:0] c,
                                                     input logic [CNT_W-1:0] th,
                                                     input logic [CNT_W-1:0] re);
    return (c > th) ? re : fc_dec(c);
  endfunction

endpackage

// File: rtl/fc_err_counters.sv
module fc_err_counters
  import can_fc_pkg::*;
#(
  parameter logic [CNT_W-1:0] TX_STEP     = 8'd8,
  parameter logic [CNT_W-1:0] RX_BIG_STEP = 8'd8,
  parameter logic [CNT_W-1:0] PASSIVE_TH  = 8'd127,
  parameter logic [CNT_W-1:0] RX_REENTER  = 8'd119
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             recover,
  input  logic             tx_fail,
  input  logic             tx_ok,
  input  logic             rx_fail,
  input  logic             rx_fail_big,
  input  logic             rx_ok,
  output logic [CNT_W-1:0] tx_cnt,
  output logic [CNT_W-1:0] rx_cnt,
  output logic             bus_off
);

  logic [CNT_W:0] tx_sum;
  logic           tx_overflow;

  assign tx_sum      = fc_wide_add(tx_cnt, TX_STEP);
  assign tx_overflow = tx_sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      bus_off <= 1'b0;
    end else if (clr) begin
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      bus_off <= 1'b0;
    end else if (bus_off) begin
      if (recover) begin
        tx_cnt  <= '0;
        rx_cnt  <= '0;
        bus_off <= 1'b0;
      end
    end else begin
      if (tx_fail) begin
        if (tx_overflow) begin
          tx_cnt  <= '1;
          bus_off <= 1'b1;
        end else begin
          tx_cnt <= tx_sum[CNT_W-1:0];
        end
      end else if (tx_ok) begin
        tx_cnt <= fc_dec(tx_cnt);
      end
      if (rx_fail_big)
        rx_cnt <= fc_sat_add(rx_cnt, RX_BIG_STEP);
      else if (rx_fail)
        rx_cnt <= fc_sat_add(rx_cnt, CNT_W'(1));
      else if (rx_ok)
        rx_cnt <= fc_rx_success(rx_cnt, PASSIVE_TH, RX_REENTER);
    end
  end

  // R3: bus-off freezes both counters until recovery or clear
  p_busoff_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !clr && !recover) |=> (bus_off && tx_cnt == '1 && $stable(rx_cnt)));

  // R4: recovery clears everything
  p_recover_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && recover) |=> (!bus_off && tx_cnt == '0 && rx_cnt == '0));

  // R2: a transmit error moves the count by the fixed step unless bus-off follows
  p_tx_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off && !clr && tx_fail) |=> (bus_off || tx_cnt == $past(tx_cnt) + TX_STEP));

  // R5: clear by software write
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tx_cnt == '0 && rx_cnt == '0 && !bus_off));

endmodule

// File: rtl/fc_capture.sv
module fc_capture
  import can_fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              err_evt,
  input  logic [TYPE_W-1:0] err_type,
  input  logic              err_dir,
  input  logic [SEG_W-1:0]  err_seg,
  input  logic              arb_lost,
  input  logic [POS_W-1:0]  arb_pos,
  output err_cap_t          cap_q,
  output logic [POS_W-1:0]  arb_q,
  output logic              ev_bus_err,
  output logic              ev_arb_lost
);

  err_cap_t cap_in;

  always_comb begin
    cap_in.etype = err_type;
    cap_in.dir   = err_dir;
    cap_in.seg   = err_seg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q       <= '0;
      arb_q       <= '0;
      ev_bus_err  <= 1'b0;
      ev_arb_lost <= 1'b0;
    end else begin
      ev_bus_err  <= err_evt;
      ev_arb_lost <= arb_lost;
      if (clr) begin
        cap_q <= '0;
        arb_q <= '0;
      end else begin
        if (err_evt)
          cap_q <= cap_in;
        if (arb_lost)
          arb_q <= arb_pos;
      end
    end
  end

  // R8: the event pulse follows a reported error by one cycle
  p_ev_berr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |-> $past(err_evt));

  // R8: captured type matches the reported one
  p_cap_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !clr) |=> (cap_q.etype == $past(err_type) && cap_q.seg == $past(err_seg)));

  // R9: arbitration event follows the loss report
  p_ev_arb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !clr) |=> (ev_arb_lost && arb_q == $past(arb_pos)));

endmodule

// File: rtl/fc_state_eval.sv
module fc_state_eval
  import can_fc_pkg::*;
#(
  parameter logic [CNT_W-1:0] PASSIVE_TH = 8'd127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             bus_off,
  input  logic [CNT_W-1:0] limit,
  output logic             err_stat,
  output logic             passive,
  output node_st_e         node_state,
  output logic             ev_warn,
  output logic             ev_passive
);

  logic err_stat_q, bus_off_q, passive_q;

  assign err_stat = (tx_cnt >= limit) || (rx_cnt >= limit);
  assign passive  = (tx_cnt > PASSIVE_TH) || (rx_cnt > PASSIVE_TH);

  always_comb begin
    if (bus_off)      node_state = ND_BUSOFF;
    else if (passive) node_state = ND_PASSIVE;
    else              node_state = ND_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_stat_q <= 1'b0;
      bus_off_q  <= 1'b0;
      passive_q  <= 1'b0;
    end else begin
      err_stat_q <= err_stat;
      bus_off_q  <= bus_off;
      passive_q  <= passive;
    end
  end

  assign ev_warn    = (err_stat != err_stat_q) || (bus_off != bus_off_q);
  assign ev_passive = (passive != passive_q);

  // R10: every change of the passive condition is reported
  p_passive_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(passive) |-> ev_passive);

  // R11: every change of warning or bus-off status is reported
  p_warn_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(err_stat) || !$stable(bus_off)) |-> ev_warn);

  // R7: bus-off dominates the state encoding
  p_busoff_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |-> (node_state == ND_BUSOFF));

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter logic [CNT_W-1:0] LIMIT_RST   = 8'd96,
  parameter logic [CNT_W-1:0] PASSIVE_TH  = 8'd127,
  parameter logic [CNT_W-1:0] RX_REENTER  = 8'd119,
  parameter logic [CNT_W-1:0] TX_STEP     = 8'd8,
  parameter logic [CNT_W-1:0] RX_BIG_STEP = 8'd8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_fail,
  input  logic        tx_ok,
  input  logic        rx_fail,
  input  logic        rx_fail_big,
  input  logic        rx_ok,
  input  logic        recover,
  input  logic        err_evt,
  input  logic [1:0]  err_type,
  input  logic        err_dir,
  input  logic [4:0]  err_seg,
  input  logic        arb_lost,
  input  logic [4:0]  arb_pos,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] cnt_word,
  output logic [7:0]  limit_word,
  output logic [31:0] status_word,
  output logic [1:0]  node_state,
  output logic        ev_warn,
  output logic        ev_passive,
  output logic        ev_bus_err,
  output logic        ev_arb_lost
);

  localparam int WORD_W  = 32;
  localparam int RX_LSB  = 16;
  localparam int RX_MSB  = RX_LSB + CNT_W - 1;

  logic [CNT_W-1:0] tx_cnt, rx_cnt, limit_q;
  logic             bus_off, clr, err_stat, passive;
  err_cap_t         cap_q;
  logic [POS_W-1:0] arb_q;
  node_st_e         st;

  assign clr = wr_en && !wr_sel && (wr_data == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      limit_q <= LIMIT_RST;
    else if (wr_en && wr_sel)
      limit_q <= wr_data[CNT_W-1:0];
  end

  fc_err_counters #(
    .TX_STEP(TX_STEP), .RX_BIG_STEP(RX_BIG_STEP),
    .PASSIVE_TH(PASSIVE_TH), .RX_REENTER(RX_REENTER)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .recover(recover),
    .tx_fail(tx_fail), .tx_ok(tx_ok), .rx_fail(rx_fail),
    .rx_fail_big(rx_fail_big), .rx_ok(rx_ok),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .bus_off(bus_off)
  );

  fc_capture u_cap (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .err_evt(err_evt), .err_type(err_type), .err_dir(err_dir), .err_seg(err_seg),
    .arb_lost(arb_lost), .arb_pos(arb_pos),
    .cap_q(cap_q), .arb_q(arb_q),
    .ev_bus_err(ev_bus_err), .ev_arb_lost(ev_arb_lost)
  );

  fc_state_eval #(.PASSIVE_TH(PASSIVE_TH)) u_st (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .bus_off(bus_off), .limit(limit_q),
    .err_stat(err_stat), .passive(passive), .node_state(st),
    .ev_warn(ev_warn), .ev_passive(ev_passive)
  );

  always_comb begin
    cnt_word                 = '0;
    cnt_word[CNT_W-1:0]      = tx_cnt;
    cnt_word[RX_MSB:RX_LSB]  = rx_cnt;
  end

  always_comb begin
    status_word        = '0;
    status_word[23:22] = cap_q.etype;
    status_word[21]    = cap_q.dir;
    status_word[20:16] = cap_q.seg;
    status_word[12:8]  = arb_q;
    status_word[7]     = bus_off;
    status_word[6]     = err_stat;
  end

  assign limit_word = limit_q;
  assign node_state = st;

  // R1: no stray bits in the counter word
  p_cnt_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_word[WORD_W-1:RX_MSB+1] == '0) && (cnt_word[RX_LSB-1:CNT_W] == '0));

  // R6: limit holds unless written
  p_limit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(limit_word));

  // R7: passive state only when a counter is above the threshold
  p_passive_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == ND_PASSIVE) |-> passive);

endmodule

// File: tb/test_can_fault_conf.sv
`timescale 1ns/1ps
module test_can_fault_conf;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_fail = 0, tx_ok = 0, rx_fail = 0, rx_fail_big = 0, rx_ok = 0, recover = 0;
  logic err_evt = 0, err_dir = 0, arb_lost = 0, wr_en = 0, wr_sel = 0;
  logic [1:0]  err_type = 0;
  logic [4:0]  err_seg = 0, arb_pos = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] cnt_word, status_word;
  logic [7:0]  limit_word;
  logic [1:0]  node_state;
  logic ev_warn, ev_passive, ev_bus_err, ev_arb_lost;

  int total = 0, bad = 0;

  // model state
  int m_tx = 0, m_rx = 0, m_lim = 96, m_type = 0, m_dir = 0, m_seg = 0, m_arb = 0;
  bit m_bo = 0;

  always #10 clk = ~clk;

  can_fault_conf i_can_fault_conf (
    .clk(clk), .rst_n(rst_n), .tx_fail(tx_fail), .tx_ok(tx_ok), .rx_fail(rx_fail),
    .rx_fail_big(rx_fail_big), .rx_ok(rx_ok), .recover(recover),
    .err_evt(err_evt), .err_type(err_type), .err_dir(err_dir), .err_seg(err_seg),
    .arb_lost(arb_lost), .arb_pos(arb_pos),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_word(cnt_word), .limit_word(limit_word), .status_word(status_word),
    .node_state(node_state), .ev_warn(ev_warn), .ev_passive(ev_passive),
    .ev_bus_err(ev_bus_err), .ev_arb_lost(ev_arb_lost)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit f_warn(int t, int r, int l); return (t >= l) || (r >= l); endfunction
  function automatic bit f_pass(int t, int r); return (t > 127) || (r > 127); endfunction
  function automatic int f_min(int a, int b); return (a < b) ? a : b; endfunction

  // ops: 0 idle 1 tx_fail 2 tx_ok 3 rx_fail 4 rx_big 5 rx_ok 6 recover 7 wr cnt 8 wr lim
  task automatic step(input int op, input logic [31:0] d, input bit de,
                      input logic [7:0] einfo, input bit da, input logic [4:0] apos);
    bit ow, ob, op_, clear;
    int exp_state;
    string creq;
    ow = f_warn(m_tx, m_rx, m_lim); ob = m_bo; op_ = f_pass(m_tx, m_rx);
    tx_fail = (op == 1); tx_ok = (op == 2); rx_fail = (op == 3);
    rx_fail_big = (op == 4); rx_ok = (op == 5); recover = (op == 6);
    wr_en = (op == 7) || (op == 8); wr_sel = (op == 8); wr_data = d;
    err_evt = de; err_type = einfo[7:6]; err_dir = einfo[5]; err_seg = einfo[4:0];
    arb_lost = da; arb_pos = apos;
    @(posedge clk);
    @(negedge clk);
    {tx_fail, tx_ok, rx_fail, rx_fail_big, rx_ok, recover, wr_en, err_evt, arb_lost} = '0;
    // model
    clear = (op == 7) && (d == 0);
    if (clear) begin
      m_tx = 0; m_rx = 0; m_bo = 0; m_type = 0; m_dir = 0; m_seg = 0; m_arb = 0;
    end else begin
      if (m_bo) begin
        if (op == 6) begin m_tx = 0; m_rx = 0; m_bo = 0; end
      end else begin
        case (op)
          1: if (m_tx + 8 > 255) begin m_tx = 255; m_bo = 1; end else m_tx += 8;
          2: if (m_tx > 0) m_tx--;
          3: m_rx = f_min(m_rx + 1, 255);
          4: m_rx = f_min(m_rx + 8, 255);
          5: if (m_rx > 127) m_rx = 119; else if (m_rx > 0) m_rx--;
          default: ;
        endcase
      end
      if (de) begin m_type = einfo[7:6]; m_dir = einfo[5]; m_seg = einfo[4:0]; end
      if (da) m_arb = apos;
    end
    if (op == 8) m_lim = d[7:0];
    creq = (op == 6) ? "R4" : clear ? "R5" : (op == 7) ? "R5 nonzero" : m_bo ? "R3" : "R2";
    chk(creq, "tx count", cnt_word[7:0], m_tx);
    chk(creq, "rx count", cnt_word[23:16], m_rx);
    chk("R1", "counter word spare bits", {cnt_word[31:24], cnt_word[15:8]}, 0);
    chk("R3", "bus-off bit", status_word[7], m_bo);
    chk("R6", "warning bit", status_word[6], f_warn(m_tx, m_rx, m_lim));
    chk("R6", "limit", limit_word, m_lim);
    exp_state = m_bo ? 2 : f_pass(m_tx, m_rx) ? 1 : 0;
    chk("R7", "node state", node_state, exp_state);
    chk("R8", "error detail", status_word[23:16], {m_type[1:0], m_dir[0], m_seg[4:0]});
    chk("R9", "arb position", status_word[12:8], m_arb);
    chk("R8", "bus error event", ev_bus_err, de);
    chk("R9", "arb event", ev_arb_lost, da);
    chk("R10", "passive event", ev_passive, op_ != f_pass(m_tx, m_rx));
    chk("R11", "warn event", ev_warn, (ow != f_warn(m_tx, m_rx, m_lim)) || (ob != m_bo));
  endtask

  initial begin
    #(20ns * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1", "reset counter word", cnt_word, 0);
    chk("R6", "reset limit", limit_word, 96);
    chk("R7", "reset state", node_state, 0);
    chk("R3", "reset status", status_word, 0);

    // R6 limit boundary: limit 10, rx reaches 10 on the tenth error
    step(8, 32'd10, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) step(3, 0, 0, 0, 0, 0);
    // R10 enter passive, then R2 re-entry value on success
    for (int i = 0; i < 15; i++) step(4, 0, 0, 0, 0, 0);
    step(5, 0, 0, 0, 0, 0);
    step(5, 0, 0, 0, 0, 0);
    // R5 clear, nonzero write ignored
    step(7, 32'h0000_0005, 0, 0, 0, 0);
    step(7, 32'd0, 0, 0, 0, 0);
    // R3 drive to bus-off, then pulses ignored, R4 recovery
    for (int i = 0; i < 33; i++) step(1, 0, 0, 0, 0, 0);
    step(3, 0, 0, 0, 0, 0);
    step(2, 0, 0, 0, 0, 0);
    step(6, 0, 0, 0, 0, 0);
    step(6, 0, 0, 0, 0, 0);
    // R8 other error at end of frame while receiving, R9 arb position 31
    step(0, 0, 1, {2'd3, 1'b1, 5'h1A}, 1, 5'd31);
    step(0, 0, 1, {2'd2, 1'b0, 5'h0A}, 0, 0);
    step(8, 32'd96, 0, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      int r, op;
      logic [31:0] d;
      r = $urandom % 100;
      d = 0;
      if (r < 30) op = 1;
      else if (r < 40) op = 2;
      else if (r < 55) op = 3;
      else if (r < 62) op = 4;
      else if (r < 72) op = 5;
      else if (r < 76) op = 6;
      else if (r < 78) begin op = 7; d = ($urandom % 2) ? 0 : $urandom; end
      else if (r < 80) begin op = 8; d = $urandom; end
      else op = 0;
      step(op, d, ($urandom % 8) == 0, 8'($urandom), ($urandom % 8) == 0, 5'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule